// File: doc/BRIEF.md
# Serial Interrupt Start Frame Stretcher

This block is the host-side front end of a shared, open-drain serial interrupt line. In quiet mode the line sits idle. A peripheral asks for a cycle by pulling the line low for a single clock and then releasing it. The host sees that low sample and takes over the line. It keeps the line low until the total low time, counting the peripheral's own clock, reaches 4, 6 or 8 clocks. In continuous mode no peripheral request is needed. The host opens the frame itself when its frame request input is high, and it drives the full width alone.

When the low period ends, the host drives the line high for one clock and then releases it. In the clock after that release it pulses a done strobe, which tells a downstream frame sequencer that the start frame is over. The wider settings are for systems that can stop the clock. There a peripheral may miss clocks, and a 4-clock frame may be too short for it to see the low time it needs.

Top module: `sirq_start_gen`

## Requirements
- R1: While rst_ni is low and after its release, line_oe_o, line_do_o and sf_done_o are 0 until a frame starts.
- R2: In quiet mode (quiet_i=1), a line_i low sample in an idle cycle makes the host drive low (line_oe_o=1, line_do_o=0) from the next cycle for width-1 cycles, so the line is low for width clocks in total.
- R3: width_sel_i encodes the width: 00 gives 4 clocks, 01 gives 6, 10 gives 8, and 11 also gives 8.
- R4: In continuous mode (quiet_i=0), frame_req_i high in an idle cycle makes the host drive low from the next cycle for the full width.
- R5: The cycle right after the last low cycle has line_oe_o=1 and line_do_o=1 (turnaround). In the cycle after that, line_oe_o=0.
- R6: sf_done_o is high for exactly one cycle, the cycle right after the turnaround, with line_oe_o=0.
- R7: A low sample on line_i or a high frame_req_i seen during the low period, the turnaround or the done cycle is ignored. The frame keeps its length and no second frame follows.
- R8: The width is taken at the clock edge that starts the frame. A change of width_sel_i during the frame has no effect on it.
- R9: In quiet mode frame_req_i is ignored. In continuous mode a low on line_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sampled level of the serial interrupt line |
| quiet_i | input | 1 | 1 = quiet mode (peripheral starts the frame), 0 = continuous mode |
| frame_req_i | input | 1 | Host frame request, used in continuous mode only |
| width_sel_i | input | 2 | Start frame width select |
| line_oe_o | output | 1 | Host drives the line when 1 |
| line_do_o | output | 1 | Level driven when line_oe_o is 1 (0 = low, 1 = high during turnaround) |
| sf_done_o | output | 1 | One-cycle pulse when the start frame is complete |

## Verification
All state shows at the ports on every cycle, because line_oe_o, line_do_o and sf_done_o decode the current state directly. A wrong counter load or a wrong width decode makes the frame one or more cycles too short or too long, and this shows in the first cycle where the low period should have ended. A state that fails to ignore a request shows as an extra frame, or as a frame that grows longer, within a cycle or two of the stray request. The scoreboard compares all three outputs on every cycle against the sequence expected from the requirements, so any divergence is seen in the cycle it occurs.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_TURN = 2'd2,
    ST_DONE = 2'd3
  } sf_state_e;
endpackage

// File: rtl/sirq_width_dec.sv
module sirq_width_dec #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned SHORT_W = 4,
  parameter int unsigned MID_W   = 6,
  parameter int unsigned LONG_W  = 8
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] width_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   width_o = CNT_W'(SHORT_W);
      2'b01:   width_o = CNT_W'(MID_W);
      default: width_o = CNT_W'(LONG_W);
    endcase
  end

  always_comb begin
    AST_WIDTH_LEGAL: assert (width_o == CNT_W'(SHORT_W) || width_o == CNT_W'(MID_W) ||
                             width_o == CNT_W'(LONG_W)); // R3
  end
endmodule

// File: rtl/sirq_low_timer.sv
module sirq_low_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/sirq_start_fsm.sv
module sirq_start_fsm
  import sirq_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             quiet_i,
  input  logic             frame_req_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             run_o,
  output logic             oe_o,
  output logic             do_o,
  output logic             done_o
);
  sf_state_e state_q, state_d;

  // quiet: peripheral already owned one low clock
  assign load_o     = (state_q == ST_IDLE) && (quiet_i ? !line_i : frame_req_i);
  assign load_val_o = quiet_i ? (width_i - CNT_W'(2)) : (width_i - CNT_W'(1));
  assign run_o      = (state_q == ST_LOW);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_o) state_d = ST_LOW;
      ST_LOW:  if (zero_i) state_d = ST_TURN;
      ST_TURN: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign oe_o   = (state_q == ST_LOW) || (state_q == ST_TURN);
  assign do_o   = (state_q == ST_TURN);
  assign done_o = (state_q == ST_DONE);

  AST_QUIET_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_i && state_q == ST_IDLE && !line_i) |=> (oe_o && !do_o)); // R2
  AST_CONT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!quiet_i && state_q == ST_IDLE && frame_req_i) |=> (oe_o && !do_o)); // R4
  AST_MODE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && (quiet_i ? line_i : !frame_req_i)) |=> !oe_o); // R9
  AST_TURN_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW && zero_i) |=> (oe_o && do_o)); // R5
  AST_TURN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && do_o) |=> (!oe_o && done_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !oe_o)); // R7
endmodule

// File: rtl/sirq_start_gen.sv
module sirq_start_gen #(
  parameter int unsigned SHORT_W = 4,
  parameter int unsigned MID_W   = 6,
  parameter int unsigned LONG_W  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  logic       quiet_i,
  input  logic       frame_req_i,
  input  logic [1:0] width_sel_i,
  output logic       line_oe_o,
  output logic       line_do_o,
  output logic       sf_done_o
);
  localparam int unsigned MAX_W = (LONG_W > MID_W) ? ((LONG_W > SHORT_W) ? LONG_W : SHORT_W)
                                                   : ((MID_W > SHORT_W) ? MID_W : SHORT_W);
  localparam int unsigned CNT_W = $clog2(MAX_W + 1);

  logic [CNT_W-1:0] width;
  logic [CNT_W-1:0] load_val;
  logic             load, run, zero;

  sirq_width_dec #(
    .CNT_W(CNT_W), .SHORT_W(SHORT_W), .MID_W(MID_W), .LONG_W(LONG_W)
  ) u_dec (
    .sel_i  (width_sel_i),
    .width_o(width)
  );

  sirq_low_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .run_i     (run),
    .zero_o    (zero)
  );

  sirq_start_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .quiet_i    (quiet_i),
    .frame_req_i(frame_req_i),
    .width_i    (width),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .run_o      (run),
    .oe_o       (line_oe_o),
    .do_o       (line_do_o),
    .done_o     (sf_done_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!line_oe_o && !sf_done_o)); // R1
  AST_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_oe_o && sf_done_o)); // R6
endmodule

// File: tb/sirq_start_gen_test.sv
module sirq_start_gen_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       quiet = 1'b1;
  logic       frame_req = 1'b0;
  logic [1:0] width_sel = 2'b00;
  logic       periph_low = 1'b0;
  logic       line, oe, dout, done;

  always #4 clk = ~clk;

  // open-drain line with pull-up
  assign line = ~((oe & ~dout) | periph_low);

  sirq_start_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .quiet_i(quiet),
    .frame_req_i(frame_req), .width_sel_i(width_sel),
    .line_oe_o(oe), .line_do_o(dout), .sf_done_o(done)
  );

  typedef struct {
    logic  oe;
    logic  dout;
    logic  done;
    string tag;
  } exp_t;

  exp_t  q[$];
  string idle_tag = "R1";
  int    total = 0;
  int    bad = 0;
  bit    mon_on = 1'b0;
  bit    finished = 1'b0;

  function automatic int wsel(input logic [1:0] s);
    return (s == 2'b00) ? 4 : (s == 2'b01) ? 6 : 8;
  endfunction

  task automatic push(input logic o, input logic d, input logic dn, input string t);
    exp_t e;
    e.oe = o; e.dout = d; e.done = dn; e.tag = t;
    q.push_back(e);
  endtask

  task automatic push_frame(input int low_cycles, input string t);
    for (int i = 0; i < low_cycles; i++) push(1'b1, 1'b0, 1'b0, t);
    push(1'b1, 1'b1, 1'b0, "R5");
    push(1'b0, 1'b0, 1'b1, "R6");
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (mon_on) begin
      if (q.size() != 0) e = q.pop_front();
      else begin e.oe = 1'b0; e.dout = 1'b0; e.done = 1'b0; e.tag = idle_tag; end
      total++;
      if (oe !== e.oe || (e.oe && dout !== e.dout) || done !== e.done) begin
        bad++;
        $display("FAIL %s: oe/do/done=%b%b%b expected %b%b%b at %0t",
                 e.tag, oe, dout, done, e.oe, e.dout, e.done, $time);
      end
    end
  end

  task automatic drain(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic quiet_frame(input logic [1:0] sel, input logic [1:0] mid_sel, input string t);
    @(posedge clk); #2;
    idle_tag = t;
    quiet = 1'b1; width_sel = sel; periph_low = 1'b1;
    @(posedge clk); #2;
    periph_low = 1'b0;
    push_frame(wsel(sel) - 1, t);
    width_sel = mid_sel;
    drain(wsel(sel) + 4);
  endtask

  task automatic cont_frame(input logic [1:0] sel, input logic [1:0] mid_sel, input string t);
    @(posedge clk); #2;
    idle_tag = t;
    quiet = 1'b0; width_sel = sel; frame_req = 1'b1;
    @(posedge clk); #2;
    frame_req = 1'b0;
    push_frame(wsel(sel), t);
    width_sel = mid_sel;
    drain(wsel(sel) + 4);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (oe !== 1'b0 || done !== 1'b0) begin
      bad++;
      $display("FAIL R1: oe/done=%b%b expected 00 in reset", oe, done);
    end
    @(posedge clk); #2;
    rst_ni = 1'b1;
    mon_on = 1'b1;
    drain(3);

    // R2 / R3 quiet mode, every encoding
    quiet_frame(2'b00, 2'b00, "R2");
    quiet_frame(2'b01, 2'b01, "R3");
    quiet_frame(2'b10, 2'b10, "R3");
    quiet_frame(2'b11, 2'b11, "R3");

    // R4 continuous mode
    cont_frame(2'b00, 2'b00, "R4");
    cont_frame(2'b01, 2'b01, "R4");
    cont_frame(2'b11, 2'b11, "R4");

    // R8 width change mid-frame
    quiet_frame(2'b00, 2'b10, "R8");
    cont_frame(2'b10, 2'b00, "R8");

    // R7 quiet: peripheral pulls low during turnaround and done
    @(posedge clk); #2;
    idle_tag = "R7";
    quiet = 1'b1; width_sel = 2'b01; periph_low = 1'b1;
    @(posedge clk); #2;
    periph_low = 1'b0;
    push_frame(5, "R7");
    repeat (5) @(posedge clk); #2;
    periph_low = 1'b1;
    repeat (2) @(posedge clk); #2;
    periph_low = 1'b0;
    drain(6);

    // R7 continuous: request held through the frame
    @(posedge clk); #2;
    quiet = 1'b0; width_sel = 2'b00; frame_req = 1'b1;
    @(posedge clk); #2;
    push_frame(4, "R7");
    repeat (4) @(posedge clk); #2;
    frame_req = 1'b0;
    drain(6);

    // R9 quiet mode ignores frame_req_i
    @(posedge clk); #2;
    idle_tag = "R9";
    quiet = 1'b1; frame_req = 1'b1;
    @(posedge clk); #2;
    frame_req = 1'b0;
    drain(4);

    // R9 continuous mode ignores a low line
    @(posedge clk); #2;
    quiet = 1'b0; periph_low = 1'b1;
    @(posedge clk); #2;
    periph_low = 1'b0;
    drain(4);

    @(posedge clk); #2;
    if (q.size() != 0) begin
      bad++; total++;
      $display("FAIL R6: scoreboard left=%0d expected 0", q.size());
    end
    mon_on = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule